// File: doc/BRIEF.md
# Processor bus machine-cycle sequencer

This block is the bus front end of a small 8-bit processor. It runs instructions as fixed, ordered lists of bus machine cycles. Each cycle has a type: opcode fetch, memory read, memory write, I/O read or I/O write. One clock is one T-state. In T1 of every machine cycle the block puts a 16-bit address on the bus, with the low byte on a multiplexed address/data bus, and pulses an address latch enable. After T1 the multiplexed bus carries data. Active-low read and write strobes qualify the transfer, and an I/O select line marks port cycles.

The block holds a program counter, an accumulator, register B and an address pair used as a memory pointer. It decodes four instructions: load B immediate (06h), increment the byte at the pointer (34h), input from a port (DBh) and store the accumulator at a direct address (32h). Any other opcode costs one fetch and does nothing else. External logic latches the address on the falling edge of the latch enable and answers read strobes on the data input.

Top module: `bus_cycle_seq`

## Requirements
- R1: While rst_ni is low, rd_no and wr_no are 1, ale_o and io_sel_o are 0, pc_o is 0, b_o is 0 and acc_o equals the RST_ACC parameter.
- R2: Every machine cycle starts with a T1 in which ale_o is 1 for exactly one clock, addr_hi_o carries address bits 15:8 and ad_o carries bits 7:0. ale_o is 0 in every other T-state, and no strobe is active while ale_o is 1.
- R3: A read or write strobe is low in T2 and T3 only, and rd_no and wr_no are never low together. In a write cycle, ad_oe_o is 1 and ad_o holds the same write byte through T2 and T3. Read data on ad_i is taken at the end of T3.
- R4: An opcode fetch lasts 4 T-states, and its T4 has no strobe and no bus drive. Memory read, memory write, I/O read and I/O write cycles last 3 T-states. The program counter changes only at the end of a machine cycle.
- R5: io_sel_o is 1 for the whole of an I/O cycle and 0 in memory cycles. During the T1 of an I/O cycle, the 8-bit port number appears on both addr_hi_o and ad_o.
- R6: Opcode 06h runs a fetch, then a memory read at the next address. The byte read is loaded into B, and the program counter advances by 2.
- R7: Opcode 34h runs a fetch, then a memory read at the pointer address (parameter RST_HL), then a memory write of that byte plus one, modulo 256, to the same address. The program counter advances by 1.
- R8: Opcode DBh runs a fetch, a memory read of the port byte at the next address, and an I/O read of that port. The result is loaded into the accumulator, and the program counter advances by 2.
- R9: Opcode 32h runs a fetch and two memory reads, low address byte first and then high address byte, at the next two addresses. It then runs a memory write of the accumulator to the combined address, and the program counter advances by 3.
- R10: Any opcode other than 06h, 34h, DBh and 32h runs one fetch only. The program counter advances by 1, and accumulator, B and memory are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one T-state per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 8 | Read data returned on the multiplexed bus |
| addr_hi_o | output | 8 | Upper address byte |
| ad_o | output | 8 | Multiplexed bus out: low address in T1, write data in T2/T3 |
| ad_oe_o | output | 1 | Multiplexed bus drive enable |
| ale_o | output | 1 | Address latch enable, high in T1 |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_sel_o | output | 1 | High for I/O cycles, low for memory cycles |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| b_o | output | 8 | Register B |

## Verification
The assertions assume that reset is held for at least one clock and that ad_i is settled before the clock edge that ends T3 of a read. They place no limits on data values, because any byte may be read or stored. The stimulus model answers reads combinationally from the address it latched in T1, and it keeps the store targets and the pointer area clear of the program bytes, so the stream of fetched opcodes matches the bench's own instruction model.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 2 * DW;
  localparam int unsigned STEP_W = 3;

  typedef enum logic [2:0] {
    CYC_FETCH, CYC_MEM_RD, CYC_MEM_WR, CYC_IO_RD, CYC_IO_WR
  } cyc_e;

  typedef enum logic [1:0] {TS_1, TS_2, TS_3, TS_4} tst_e;

  typedef enum logic [1:0] {AS_PC, AS_PTR, AS_PORT, AS_DIRECT} asel_e;
  typedef enum logic {WS_INC, WS_ACC} wsel_e;
  typedef enum logic [2:0] {DS_NONE, DS_OPC, DS_B, DS_TLO, DS_THI, DS_ACC} dsel_e;

  typedef struct packed {
    cyc_e          kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } bus_req_t;

  localparam logic [DW-1:0] OP_LDB_IMM   = 8'h06;
  localparam logic [DW-1:0] OP_INC_PTR   = 8'h34;
  localparam logic [DW-1:0] OP_PORT_IN   = 8'hDB;
  localparam logic [DW-1:0] OP_STORE_DIR = 8'h32;

  function automatic logic cyc_reads(cyc_e k);
    return (k == CYC_FETCH) || (k == CYC_MEM_RD) || (k == CYC_IO_RD);
  endfunction

  function automatic logic cyc_writes(cyc_e k);
    return (k == CYC_MEM_WR) || (k == CYC_IO_WR);
  endfunction

  function automatic logic cyc_is_io(cyc_e k);
    return (k == CYC_IO_RD) || (k == CYC_IO_WR);
  endfunction
endpackage

// File: rtl/bcs_plan.sv
// Per-opcode machine-cycle list: what the cycle at step_i does.
module bcs_plan
  import bcs_pkg::*;
(
  input  logic [DW-1:0]     opc_i,
  input  logic [STEP_W-1:0] step_i,
  output cyc_e              kind_o,
  output asel_e             asel_o,
  output wsel_e             wsel_o,
  output dsel_e             dsel_o,
  output logic              pc_inc_o,
  output logic              last_o
);
  logic known;
  assign known = (opc_i == OP_LDB_IMM) || (opc_i == OP_INC_PTR) ||
                 (opc_i == OP_PORT_IN) || (opc_i == OP_STORE_DIR);

  always_comb begin
    kind_o   = CYC_FETCH;
    asel_o   = AS_PC;
    wsel_o   = WS_INC;
    dsel_o   = DS_NONE;
    pc_inc_o = 1'b0;
    last_o   = 1'b1;
    if (step_i == '0) begin
      dsel_o   = DS_OPC;
      pc_inc_o = 1'b1;
      last_o   = !known;
    end else begin
      case (opc_i)
        OP_LDB_IMM: begin
          kind_o = CYC_MEM_RD; dsel_o = DS_B; pc_inc_o = 1'b1;
        end
        OP_INC_PTR: begin
          asel_o = AS_PTR;
          if (step_i == STEP_W'(1)) begin
            kind_o = CYC_MEM_RD; dsel_o = DS_TLO; last_o = 1'b0;
          end else begin
            kind_o = CYC_MEM_WR; wsel_o = WS_INC;
          end
        end
        OP_PORT_IN: begin
          if (step_i == STEP_W'(1)) begin
            kind_o = CYC_MEM_RD; dsel_o = DS_TLO; pc_inc_o = 1'b1; last_o = 1'b0;
          end else begin
            kind_o = CYC_IO_RD; asel_o = AS_PORT; dsel_o = DS_ACC;
          end
        end
        OP_STORE_DIR: begin
          if (step_i == STEP_W'(1)) begin
            kind_o = CYC_MEM_RD; dsel_o = DS_TLO; pc_inc_o = 1'b1; last_o = 1'b0;
          end else if (step_i == STEP_W'(2)) begin
            kind_o = CYC_MEM_RD; dsel_o = DS_THI; pc_inc_o = 1'b1; last_o = 1'b0;
          end else begin
            kind_o = CYC_MEM_WR; asel_o = AS_DIRECT; wsel_o = WS_ACC;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bcs_bus_unit.sv
// T-state engine: drives strobes, latch enable and bus for the requested cycle.
module bcs_bus_unit
  import bcs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_req_t      req_i,
  output logic          cyc_end_o,
  output logic          rd_cap_o,
  output logic [DW-1:0] addr_hi_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic          io_sel_o
);
  logic run_q;
  tst_e t_q;
  logic last_t, strobe_t, rd_k, wr_k;

  assign rd_k     = cyc_reads(req_i.kind);
  assign wr_k     = cyc_writes(req_i.kind);
  assign last_t   = (req_i.kind == CYC_FETCH) ? (t_q == TS_4) : (t_q == TS_3);
  assign strobe_t = run_q && ((t_q == TS_2) || (t_q == TS_3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      t_q   <= TS_1;
    end else begin
      run_q <= 1'b1;
      if (run_q) t_q <= last_t ? TS_1 : tst_e'(t_q + 2'd1);
    end
  end

  assign cyc_end_o = run_q && last_t;
  assign rd_cap_o  = run_q && (t_q == TS_3) && rd_k;
  assign ale_o     = run_q && (t_q == TS_1);
  assign addr_hi_o = run_q ? req_i.addr[AW-1:DW] : '0;
  assign ad_oe_o   = ale_o || (strobe_t && wr_k);
  assign ad_o      = ale_o ? req_i.addr[DW-1:0] :
                     (strobe_t && wr_k) ? req_i.wdata : '0;
  assign rd_no     = !(strobe_t && rd_k);
  assign wr_no     = !(strobe_t && wr_k);
  assign io_sel_o  = run_q && cyc_is_io(req_i.kind);

  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  assert_ale_one_tstate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  assert_no_strobe_in_t1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no));
  assert_wr_two_tstates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |=> !wr_no ##1 wr_no);
  assert_t4_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && t_q == TS_4) |-> (rd_no && wr_no && !ad_oe_o && !ale_o));
  assert_io_port_both_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_o && ale_o) |-> (addr_hi_o == ad_o));
endmodule

// File: rtl/bcs_datapath.sv
// Registers, step counter and bus request formation.
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter logic [DW-1:0] RST_ACC = 8'h00,
  parameter logic [AW-1:0] RST_HL  = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_end_i,
  input  logic              rd_cap_i,
  input  logic [DW-1:0]     rdata_i,
  input  cyc_e              kind_i,
  input  asel_e             asel_i,
  input  wsel_e             wsel_i,
  input  dsel_e             dsel_i,
  input  logic              pc_inc_i,
  input  logic              last_i,
  output logic [DW-1:0]     opc_o,
  output logic [STEP_W-1:0] step_o,
  output bus_req_t          req_o,
  output logic [AW-1:0]     pc_o,
  output logic [DW-1:0]     acc_o,
  output logic [DW-1:0]     b_o
);
  logic [AW-1:0]     pc_q, hl_q;
  logic [DW-1:0]     acc_q, b_q, opc_q, tlo_q, thi_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      hl_q   <= RST_HL;
      acc_q  <= RST_ACC;
      b_q    <= '0;
      opc_q  <= '0;
      tlo_q  <= '0;
      thi_q  <= '0;
      step_q <= '0;
    end else begin
      if (rd_cap_i) begin
        case (dsel_i)
          DS_OPC: opc_q <= rdata_i;
          DS_B:   b_q   <= rdata_i;
          DS_TLO: tlo_q <= rdata_i;
          DS_THI: thi_q <= rdata_i;
          DS_ACC: acc_q <= rdata_i;
          default: ;
        endcase
      end
      if (cyc_end_i) begin
        if (pc_inc_i) pc_q <= pc_q + AW'(1);
        step_q <= last_i ? '0 : step_q + STEP_W'(1);
      end
    end
  end

  always_comb begin
    req_o.kind = kind_i;
    case (asel_i)
      AS_PTR:    req_o.addr = hl_q;
      AS_PORT:   req_o.addr = {tlo_q, tlo_q};
      AS_DIRECT: req_o.addr = {thi_q, tlo_q};
      default:   req_o.addr = pc_q;
    endcase
    req_o.wdata = (wsel_i == WS_ACC) ? acc_q : tlo_q + DW'(1);
  end

  assign opc_o  = opc_q;
  assign step_o = step_q;
  assign pc_o   = pc_q;
  assign acc_o  = acc_q;
  assign b_o    = b_q;

  assert_pc_moves_at_cycle_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_q) |-> $past(cyc_end_i));
  assert_step_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= STEP_W'(3));
  assert_ptr_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hl_q == RST_HL);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter logic [7:0]  RST_ACC = 8'hC7,
  parameter logic [15:0] RST_HL  = 16'h0250
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  ad_i,
  output logic [7:0]  addr_hi_o,
  output logic [7:0]  ad_o,
  output logic        ad_oe_o,
  output logic        ale_o,
  output logic        rd_no,
  output logic        wr_no,
  output logic        io_sel_o,
  output logic [15:0] pc_o,
  output logic [7:0]  acc_o,
  output logic [7:0]  b_o
);
  logic [DW-1:0]     opc;
  logic [STEP_W-1:0] step;
  cyc_e              kind;
  asel_e             asel;
  wsel_e             wsel;
  dsel_e             dsel;
  logic              pc_inc, last, cyc_end, rd_cap;
  bus_req_t          req;

  bcs_plan u_plan (
    .opc_i(opc), .step_i(step), .kind_o(kind), .asel_o(asel),
    .wsel_o(wsel), .dsel_o(dsel), .pc_inc_o(pc_inc), .last_o(last)
  );

  bcs_datapath #(.RST_ACC(RST_ACC), .RST_HL(RST_HL)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_end_i(cyc_end), .rd_cap_i(rd_cap),
    .rdata_i(ad_i), .kind_i(kind), .asel_i(asel), .wsel_i(wsel), .dsel_i(dsel),
    .pc_inc_i(pc_inc), .last_i(last), .opc_o(opc), .step_o(step), .req_o(req),
    .pc_o(pc_o), .acc_o(acc_o), .b_o(b_o)
  );

  bcs_bus_unit u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .cyc_end_o(cyc_end),
    .rd_cap_o(rd_cap), .addr_hi_o(addr_hi_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .ale_o(ale_o), .rd_no(rd_no), .wr_no(wr_no), .io_sel_o(io_sel_o)
  );
endmodule

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;
  localparam logic [7:0]  ACC0 = 8'hC7;
  localparam logic [15:0] PTR  = 16'h0250;
  localparam int K_F = 0, K_MR = 1, K_MW = 2, K_IOR = 3, K_BAD = 9;
  localparam int MAXC = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ad_i, addr_hi_o, ad_o, acc_o, b_o;
  logic ad_oe_o, ale_o, rd_no, wr_no, io_sel_o;
  logic [15:0] pc_o;

  always #2 clk = ~clk;

  bus_cycle_seq #(.RST_ACC(ACC0), .RST_HL(PTR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ad_i(ad_i), .addr_hi_o(addr_hi_o), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .ale_o(ale_o), .rd_no(rd_no), .wr_no(wr_no),
    .io_sel_o(io_sel_o), .pc_o(pc_o), .acc_o(acc_o), .b_o(b_o)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] mem [1024];
  logic [7:0] mm  [1024];
  int exp_kind [MAXC];
  logic [15:0] exp_addr [MAXC];
  logic [7:0]  exp_data [MAXC];
  string       exp_tag  [MAXC];
  int n_exp = 0, obs_n = 0;
  logic [7:0]  m_acc, m_b;
  logic [15:0] m_pc;

  logic [15:0] lat_addr = '0;
  logic        lat_io = 1'b0;
  assign ad_i = lat_io ? (lat_addr[7:0] ^ 8'h5A) : mem[lat_addr[9:0]];

  function automatic logic [7:0] port_val(logic [7:0] p);
    return p ^ 8'h5A;
  endfunction

  task automatic chk(string tag, logic ok, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(int k, logic [15:0] a, logic [7:0] d, string tag);
    exp_kind[n_exp] = k; exp_addr[n_exp] = a; exp_data[n_exp] = d; exp_tag[n_exp] = tag;
    n_exp++;
  endtask

  task automatic place(logic [15:0] a, logic [7:0] v);
    mem[a[9:0]] = v; mm[a[9:0]] = v;
  endtask

  // Instruction model: lays out bytes and predicts the cycle list.
  task automatic emit(logic [7:0] op, logic [7:0] x, logic [7:0] y);
    logic [7:0] v;
    place(m_pc, op);
    case (op)
      8'h06: begin
        place(m_pc + 1, x);
        push(K_F, m_pc, op, "R6"); push(K_MR, m_pc + 1, x, "R6");
        m_b = x; m_pc += 2;
      end
      8'h34: begin
        v = mm[PTR[9:0]];
        push(K_F, m_pc, op, "R7"); push(K_MR, PTR, v, "R7"); push(K_MW, PTR, v + 8'd1, "R7");
        mm[PTR[9:0]] = v + 8'd1; m_pc += 1;
      end
      8'hDB: begin
        place(m_pc + 1, x);
        push(K_F, m_pc, op, "R8"); push(K_MR, m_pc + 1, x, "R8");
        push(K_IOR, {x, x}, port_val(x), "R5");
        m_acc = port_val(x); m_pc += 2;
      end
      8'h32: begin
        place(m_pc + 1, x); place(m_pc + 2, y);
        push(K_F, m_pc, op, "R9"); push(K_MR, m_pc + 1, x, "R9"); push(K_MR, m_pc + 2, y, "R9");
        push(K_MW, {y, x}, m_acc, "R9");
        mm[{y[1:0], x}] = m_acc; m_pc += 3;
      end
      default: begin
        push(K_F, m_pc, op, "R10"); m_pc += 1;
      end
    endcase
  endtask

  // Bus monitor, sampled mid T-state
  logic r_act = 0, r_io = 0, r_rd = 0, r_wr = 0, r_bad = 0, ale_prev = 0;
  logic [15:0] r_addr = '0;
  logic [7:0]  r_data = '0;
  int r_len = 0, ale_dbl = 0, clash = 0;

  task automatic close_rec();
    int k;
    if (r_bad) k = K_BAD;
    else if (r_rd && !r_wr && !r_io && r_len == 4) k = K_F;
    else if (r_rd && !r_wr && !r_io && r_len == 3) k = K_MR;
    else if (r_wr && !r_rd && !r_io && r_len == 3) k = K_MW;
    else if (r_rd && !r_wr &&  r_io && r_len == 3) k = K_IOR;
    else k = K_BAD;
    if (obs_n < n_exp) begin
      chk(exp_tag[obs_n], k == exp_kind[obs_n], "cycle kind (R4)", k, exp_kind[obs_n]);
      chk(exp_tag[obs_n], r_addr == exp_addr[obs_n], "cycle address (R2)", r_addr, exp_addr[obs_n]);
      chk(exp_tag[obs_n], r_data == exp_data[obs_n], "cycle data (R3)", r_data, exp_data[obs_n]);
    end
    obs_n++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ale_o) begin
        if (ale_prev) ale_dbl++;
        if (r_act) close_rec();
        r_act = 1; r_addr = {addr_hi_o, ad_o}; r_io = io_sel_o; r_len = 1;
        r_rd = 0; r_wr = 0; r_bad = !ad_oe_o; r_data = '0;
        lat_addr = {addr_hi_o, ad_o}; lat_io = io_sel_o;
        if (!rd_no || !wr_no) clash++;
      end else if (r_act) begin
        r_len++;
        if (io_sel_o != r_io) r_bad = 1;
        if (!rd_no) begin r_rd = 1; r_data = ad_i; end
        if (!wr_no) begin
          if (r_wr && ad_o != r_data) r_bad = 1;
          if (!ad_oe_o) r_bad = 1;
          r_wr = 1; r_data = ad_o;
          if (!io_sel_o) mem[lat_addr[9:0]] = ad_o;
        end
      end
      if (!rd_no && !wr_no) clash++;
      ale_prev = ale_o;
    end
  end

  initial begin
    int unsigned seed_v;
    int cyc;
    logic [7:0] op;
    logic [31:0] mism;
    seed_v = $urandom(32'h1F2E3D4C);
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'h00; mm[i] = 8'h00; end
    m_acc = ACC0; m_b = 8'h00; m_pc = 16'h0000;
    place(PTR, 8'hFF);                       // R7 wrap corner
    emit(8'h32, 8'h00, 8'h03);               // R9 store reset acc to 0300h
    emit(8'h76, 8'h00, 8'h00);               // R10 unknown opcode
    emit(8'h34, 8'h00, 8'h00);               // R7 FF -> 00
    emit(8'h34, 8'h00, 8'h00);               // R7 00 -> 01
    emit(8'h06, 8'hFF, 8'h00);               // R6
    emit(8'hDB, 8'h00, 8'h00);               // R8 port 00
    emit(8'hDB, 8'hFF, 8'h00);               // R8 port FF
    emit(8'h32, 8'hFF, 8'h03);               // R9 store to 03FFh
    for (int i = 0; i < 50; i++) begin
      case ($urandom % 5)
        0: op = 8'h06;
        1: op = 8'h34;
        2: op = 8'hDB;
        3: op = 8'h32;
        default: begin
          op = 8'($urandom);
          while (op == 8'h06 || op == 8'h34 || op == 8'hDB || op == 8'h32) op = 8'($urandom);
        end
      endcase
      emit(op, 8'($urandom), 8'h03);
    end
    emit(8'h00, 8'h00, 8'h00);
    emit(8'h00, 8'h00, 8'h00);

    repeat (3) @(posedge clk);
    #1;
    chk("R1", rd_no && wr_no, "strobes idle in reset", {rd_no, wr_no}, 2'b11);
    chk("R1", !ale_o && !io_sel_o, "ale/io low in reset", {ale_o, io_sel_o}, 0);
    chk("R1", pc_o == 16'h0, "pc reset", pc_o, 0);
    chk("R1", acc_o == ACC0, "acc reset", acc_o, ACC0);
    chk("R1", b_o == 8'h00, "b reset", b_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    cyc = 0;
    while (obs_n < n_exp && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    #1;
    chk("R4", cyc < 20000, "watchdog", cyc, 20000);
    chk("R8", acc_o == m_acc, "final accumulator", acc_o, m_acc);
    chk("R6", b_o == m_b, "final B", b_o, m_b);
    chk("R10", pc_o == m_pc, "final pc", pc_o, m_pc);
    mism = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] != mm[i]) mism++;
    chk("R9", mism == 0, "memory image mismatches (R7 R9 R10)", mism, 0);
    chk("R2", ale_dbl == 0, "ale wider than one T-state", ale_dbl, 0);
    chk("R3", clash == 0, "strobe overlap or strobe in T1", clash, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule